// File: doc/BRIEF.md
# Sync-Locked Burst Scheduler

This block decides the clock cycle in which each acquisition burst begins. Without an external sync reference it free-runs. The next burst starts a fixed discharge gap after the acquisition engine reports that the current burst is done. The start-to-start spacing is therefore the burst's own length plus the gap. The burst length is never assumed, because it varies with the sensed load.

Rising edges on the sync pin lock the scheduler to the external reference. Each eligible edge starts a burst. An edge is dropped if it lands while a burst is running or while the discharge gap is still open. After a drop, the scheduler waits for a later edge.

If edges stop arriving for the loss timeout, the lock is released and free-running resumes. A later edge locks the scheduler again. No burst is issued during the power-up hold after reset. All time constants are counts of `clk_i` cycles.

Top module: `burst_sched`

## Requirements
- R1: After reset release, `ready_o` stays low and `burst_start_o` stays low for PWRUP_CYC clock cycles. `ready_o` then goes high and stays high until the next reset.
- R2: While unlocked, the first burst start appears in the cycle after `ready_o` rises.
- R3: `burst_start_o` is a single-cycle pulse. No further start occurs until `burst_done_i` is sampled high during the burst. A `burst_done_i` pulse outside a burst has no effect on the start timing.
- R4: While unlocked, the next `burst_start_o` is asserted exactly GAP_CYC cycles after the clock edge that sampled `burst_done_i` high. The start-to-start spacing is therefore burst length plus GAP_CYC.
- R5: `sync_i` passes through a two-flop synchronizer followed by an edge detector. A low-to-high change first sampled at clock edge P is detected at edge P+1. When the scheduler is locked and waiting, it raises `burst_start_o` after edge P+2.
- R6: A detected edge that falls inside a burst, or fewer than GAP_CYC cycles after the done edge, starts nothing.
- R7: The first detected edge at or after the end of the gap starts a burst in the cycle it is detected. This includes an edge that coincides with the last gap cycle, and it holds when edges arrive faster than bursts complete.
- R8: Every detected rising edge sets `sync_lock_o` in the same cycle that a start triggered by that edge would appear. This applies even when the edge itself is dropped.
- R9: `sync_lock_o` falls LOSS_CYC cycles after the last detected edge. Edges dropped by the lockout still restart this timeout.
- R10: If the lock falls while the scheduler waits after a gap, a free-running start follows one cycle later.
- R11: After a loss, the next detected edge locks the scheduler again. From then on the scheduler waits for eligible edges instead of free-running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Raw external sync pin, asynchronous |
| burst_done_i | input | 1 | Strobe from the acquisition engine: the current burst has finished |
| burst_start_o | output | 1 | One-cycle pulse: begin an acquisition burst |
| sync_lock_o | output | 1 | High while bursts are locked to sync edges |
| ready_o | output | 1 | Power-up hold has elapsed |

## Verification
The bench sweeps the arrival of a single sync edge across every cycle offset from the done strobe to two cycles past the end of the gap. An off-by-one lockout would either start a burst inside the discharge gap or drop the first legal edge. It also sweeps burst lengths in free-running mode and injects a stray done strobe mid-gap. A design that measured spacing from the start, or that re-armed on a stray strobe, would show the wrong start cycle.

For every dropped edge, the bench tracks the lock through the full loss timeout. A design that only restarted the timeout on accepted edges would release the lock early. A design that forgot to resume free-running would never start again. A train of edges faster than the burst rate checks that only the first edge past the gap is taken.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } sched_st_e;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sync_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
  parameter int unsigned LOSS_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic lock_o
);
  localparam int unsigned LW = $clog2(LOSS_CYC + 1);

  logic [LW-1:0] cnt_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b1;
    end else if (lock_q) begin
      if (cnt_q == LW'(LOSS_CYC - 1)) begin
        cnt_q  <= '0;
        lock_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int unsigned PWRUP_CYC = 300000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned PW = $clog2(PWRUP_CYC + 1);

  logic [PW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == PW'(PWRUP_CYC - 1)) ready_q <= 1'b1;
      else                             cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_sched_pkg::*;
#(
  parameter int unsigned PWRUP_CYC   = 300000,
  parameter int unsigned GAP_CYC     = 2500,
  parameter int unsigned LOSS_CYC    = 100000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic burst_done_i,
  output logic burst_start_o,
  output logic sync_lock_o,
  output logic ready_o
);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);

  logic rise, lock, ready;

  sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .rise_o (rise)
  );

  lock_watch #(.LOSS_CYC(LOSS_CYC)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .lock_o (lock)
  );

  pwrup_timer #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_o (ready)
  );

  sched_st_e     st_q, st_n;
  logic [GW-1:0] gap_q, gap_n;
  logic          start_q, go, trig;

  // unlocked: start as soon as allowed; locked: only on an edge
  assign trig = ~lock | rise;

  always_comb begin
    st_n  = st_q;
    gap_n = gap_q;
    go    = 1'b0;
    unique case (st_q)
      ST_WAIT: go = ready & trig;
      ST_BURST: if (burst_done_i) begin
        st_n  = ST_GAP;
        gap_n = '0;
      end
      ST_GAP: begin
        if (gap_q == GW'(GAP_CYC - 1)) begin
          // last gap cycle is already eligible
          if (trig) go = 1'b1;
          else      st_n = ST_WAIT;
        end else begin
          gap_n = gap_q + 1'b1;
        end
      end
      default: st_n = ST_WAIT;
    endcase
    if (go) st_n = ST_BURST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_WAIT;
      gap_q   <= '0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      gap_q   <= gap_n;
      start_q <= go;
    end
  end

  assign burst_start_o = start_q;
  assign sync_lock_o   = lock;
  assign ready_o       = ready;
endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk #(
  parameter int unsigned GAP_CYC = 2500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic burst_done_i,
  input logic burst_start_o,
  input logic ready_o
);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);

  logic          in_burst_q;
  logic [GW-1:0] since_done_q;
  logic          done_acc;

  assign done_acc = (in_burst_q | burst_start_o) & burst_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_burst_q   <= 1'b0;
      since_done_q <= GW'(GAP_CYC);
    end else begin
      in_burst_q <= (in_burst_q | burst_start_o) & ~burst_done_i;
      if (done_acc)                           since_done_q <= '0;
      else if (since_done_q != GW'(GAP_CYC))  since_done_q <= since_done_q + 1'b1;
    end
  end

  assert_no_start_early_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !burst_start_o);

  assert_ready_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_o |=> !burst_start_o);

  assert_no_start_in_burst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_burst_q |-> !burst_start_o);

  assert_gap_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_o |-> (since_done_q >= GW'(GAP_CYC)));
endmodule

bind burst_sched burst_sched_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .burst_done_i  (burst_done_i),
  .burst_start_o (burst_start_o),
  .ready_o       (ready_o)
);

// File: tb/sim_burst_sched.sv
`timescale 1ns/1ps
module sim_burst_sched;
  localparam int PWRUP = 20;
  localparam int GAP   = 10;
  localparam int LOSS  = 60;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 1'b0;
  logic burst_done_i = 1'b0;
  logic burst_start_o, sync_lock_o, ready_o;

  int cyc = 0;
  int nstarts = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_ni && burst_start_o) nstarts <= nstarts + 1;

  burst_sched #(.PWRUP_CYC(PWRUP), .GAP_CYC(GAP), .LOSS_CYC(LOSS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .burst_done_i(burst_done_i),
    .burst_start_o(burst_start_o), .sync_lock_o(sync_lock_o), .ready_o(ready_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cyc %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic goto(input int t);
    while (cyc < t) @(negedge clk);
    #1;
  endtask

  task automatic sync_pulse(input int c);
    goto(c); sync_i = 1'b1;
    goto(c + 2); sync_i = 1'b0;
  endtask

  task automatic done_pulse(input int d);
    goto(d); burst_done_i = 1'b1;
    goto(d + 1); burst_done_i = 1'b0;
  endtask

  initial begin
    int rel, s, d, n0, t, c;
    repeat (3) @(negedge clk);
    #1;
    check(burst_start_o == 0 && ready_o == 0 && sync_lock_o == 0, "R1 reset", int'(burst_start_o), 0);
    @(negedge clk); rst_ni = 1'b1; rel = cyc;

    goto(rel + PWRUP - 1);
    check(ready_o == 0, "R1 ready early", int'(ready_o), 0);
    check(nstarts == 0, "R1 start early", nstarts, 0);
    goto(rel + PWRUP);
    check(ready_o == 1, "R1 ready", int'(ready_o), 1);
    goto(rel + PWRUP + 1);
    check(burst_start_o == 1, "R2 first start", int'(burst_start_o), 1);
    s = rel + PWRUP + 1;

    // free-running: sweep burst lengths (R4, R3)
    for (int len = 1; len <= 6; len++) begin
      n0 = nstarts;
      d = s + len;
      done_pulse(d);
      if (len == 3) done_pulse(d + 3);  // stray strobe mid-gap
      goto(d + GAP);
      check(nstarts == n0, "R4 no early start", nstarts, n0);
      goto(d + 1 + GAP);
      check(burst_start_o == 1, "R4 start after gap", int'(burst_start_o), 1);
      goto(d + 2 + GAP);
      check(burst_start_o == 0, "R3 single pulse", int'(burst_start_o), 0);
      if (len == 3) check(nstarts == n0 + 1, "R3 stray done ignored", nstarts, n0 + 1);
      s = d + 1 + GAP;
    end

    // single-edge sweep across the lockout boundary (R5..R11)
    for (int o = 0; o <= GAP + 2; o++) begin
      n0 = nstarts;
      d = s + 3;
      c = d + o;
      fork
        done_pulse(d);
        sync_pulse(c);
      join
      if (o >= GAP - 2) begin
        t = c + 3;
        goto(t - 1);
        check(nstarts == n0, "R7 no start before edge", nstarts, n0);
        goto(t);
        check(burst_start_o == 1, "R5 start on edge", int'(burst_start_o), 1);
        check(sync_lock_o == 1, "R8 locked", int'(sync_lock_o), 1);
        s = t;
      end else begin
        goto(d + 1 + GAP);
        check(nstarts == n0, "R6 edge in lockout dropped", nstarts, n0);
        check(sync_lock_o == 1, "R11 relocked", int'(sync_lock_o), 1);
        goto(c + 2 + LOSS);
        check(sync_lock_o == 1, "R9 timeout restarted", int'(sync_lock_o), 1);
        check(nstarts == n0, "R11 waits for edge", nstarts, n0);
        goto(c + 3 + LOSS);
        check(sync_lock_o == 0, "R9 lock lost", int'(sync_lock_o), 0);
        check(burst_start_o == 0, "R10 not yet", int'(burst_start_o), 0);
        goto(c + 4 + LOSS);
        check(burst_start_o == 1, "R10 free-run resumes", int'(burst_start_o), 1);
        s = c + 4 + LOSS;
      end
    end

    // edge train faster than bursts (R7)
    goto(s);
    n0 = nstarts;
    fork
      done_pulse(s + 3);
      for (int k = 0; k < 5; k++) begin
        sync_pulse(s + 4 * k);
        goto(s + 4 * k + 4);
      end
      begin
        goto(s + 14);
        check(nstarts == n0, "R7 train held in gap", nstarts, n0);
        goto(s + 15);
        check(burst_start_o == 1, "R7 first edge past gap", int'(burst_start_o), 1);
      end
    join
    check(nstarts == n0 + 1, "R6 train edge in burst dropped", nstarts, n0 + 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule